// File: doc/BRIEF.md
# I2C Slave Address-Match Front End

This block listens to an I2C bus in the slave role and handles only the address phase of a transfer. Once enabled, it looks for a START condition. It then shifts in the first byte and compares the upper seven bits with a programmable device address. On a hit it acknowledges the byte and stores the whole byte, including the read/write flag in bit 0. It also raises a sticky interrupt and then holds SCL low. SCL stays low until the host pulses a release strobe, so the host can pick its read or write data path at its own pace. On a miss the block leaves SDA alone and ignores the bus until the next START or STOP.

The bus lines enter through a two-flop synchroniser. The outputs are open-drain pull-low requests: a 1 on `scl_pull` or `sda_pull` means "drive the line low". The states are IDLE (disabled), SEARCH (waiting for START), SHIFT (receiving the address byte), ACK (holding SDA low for the acknowledge clock), HOLD (stretching SCL) and IGNORE (address missed). The transitions are:

- IDLE→SEARCH when enabled.
- SEARCH→SHIFT on START.
- SHIFT→ACK or SHIFT→IGNORE on the SCL fall after the eighth bit.
- ACK→HOLD on the next SCL fall.
- HOLD→SEARCH on the release strobe.
- From any enabled state: START goes to SHIFT, STOP goes to SEARCH, and dropping `enable` goes to IDLE.

Top module: `i2c_addr_watch`

## Requirements
- R1: After reset with `enable` low, `scl_pull`, `sda_pull` and `irq` are 0 and `addr_byte` is 8'h00.
- R2: A byte is only received after a START (SDA falling while SCL is high). Bytes clocked in SEARCH without a START are never acknowledged.
- R3: The eight address-phase bits are taken on SCL rising edges, MSB first. Bits 7..1 of the received byte are compared with `dev_addr[6:0]`.
- R4: On a match, `sda_pull` is 1 from the SCL fall after the eighth bit until the following SCL fall, so the master reads ACK (SDA low) during the ninth clock.
- R5: On a match, `addr_byte` takes the full received byte, with the read/write flag in bit 0 (1 = read), and `irq` becomes 1.
- R6: After the acknowledge clock falls on a match, `scl_pull` stays 1 until a one-cycle `release_stb` pulse. It is 0 from the cycle after that pulse.
- R7: On a mismatch, SDA is never pulled and `irq` does not change. Further bytes are ignored until a START or STOP.
- R8: A STOP aborts a byte in progress and returns the block to SEARCH. A repeated START inside a byte restarts reception from bit 7.
- R9: `irq` stays 1 after the release strobe until `irq_clr` is pulsed, and is 0 after that pulse.
- R10: When `enable` goes low, `scl_pull` and `sda_pull` drop in the same cycle and the block returns to IDLE. While disabled nothing is acknowledged. After re-enabling, the next START with a matching address is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Slave enable |
| dev_addr | input | 7 | Programmed device address |
| release_stb | input | 1 | One-cycle pulse that ends clock stretching |
| irq_clr | input | 1 | One-cycle pulse that clears the interrupt |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_pull | output | 1 | 1 = drive SCL low |
| sda_pull | output | 1 | 1 = drive SDA low |
| irq | output | 1 | Sticky address-match interrupt |
| addr_byte | output | 8 | Last matched address byte including the R/W bit |

## Verification
The assertions check, on every cycle, the following invariants:

- The bit counter never passes eight.
- A STOP always lands in SEARCH.
- A rising interrupt coincides with the acknowledge drive.
- The interrupt is sticky.
- SCL stretching starts only after the ACK and persists until the release or disable.
- An acknowledge is only ever driven for a byte whose upper bits equal the device address.

Only the bench scenarios show the other behaviours. These are whether the right byte values produce an ACK at the master (a full sweep of all 256 byte values, plus every device address), that bytes without a START or after a miss are ignored, how repeated START and STOP abort a byte mid-way, and that dropping enable frees the bus in the same cycle.

// File: rtl/i2c_aw_pkg.sv
package i2c_aw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_SHIFT,
        ST_ACK,
        ST_HOLD,
        ST_IGNORE
    } aw_state_t;

    // One-cycle bus events derived from the synchronised lines
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

endpackage

// File: rtl/i2c_aw_sync.sv
module i2c_aw_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Lines reset to the idle (high) level so no spurious event appears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[LAST];

endmodule

// File: rtl/i2c_aw_events.sv
module i2c_aw_events
    import i2c_aw_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
        ev.sda   = sda_s;
    end

endmodule

// File: rtl/i2c_aw_fsm.sv
module i2c_aw_fsm
    import i2c_aw_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              release_stb,
    input  logic              irq_clr,
    input  bus_ev_t           ev,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              irq,
    output logic [ADDR_W:0]   addr_byte
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    aw_state_t          state;
    aw_state_t          state_nx;
    logic [BYTE_W-1:0]  shift_q;
    logic [CNT_W-1:0]   bit_cnt;
    logic               addr_hit;
    logic               enter_ack;

    assign addr_hit  = (shift_q[BYTE_W-1:1] == dev_addr);
    assign enter_ack = (state == ST_SHIFT) && (state_nx == ST_ACK);

    // Next-state decision: disable, START and STOP override every state
    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = ST_IDLE;
        end else if (ev.start) begin
            state_nx = ST_SHIFT;
        end else if (ev.stop) begin
            state_nx = ST_SEARCH;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_SEARCH;
                ST_SEARCH: state_nx = ST_SEARCH;
                ST_SHIFT: begin
                    if (ev.fall && bit_cnt == CNT_FULL)
                        state_nx = addr_hit ? ST_ACK : ST_IGNORE;
                end
                ST_ACK: begin
                    if (ev.fall) state_nx = ST_HOLD;
                end
                ST_HOLD: begin
                    if (release_stb) state_nx = ST_SEARCH;
                end
                ST_IGNORE: state_nx = ST_IGNORE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // State register and address-phase datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            shift_q   <= '0;
            bit_cnt   <= '0;
            irq       <= 1'b0;
            addr_byte <= '0;
        end else begin
            state <= state_nx;
            if (ev.start) begin
                bit_cnt <= '0;
            end else if (state == ST_SHIFT && ev.rise && bit_cnt < CNT_FULL) begin
                shift_q <= {shift_q[BYTE_W-2:0], ev.sda};
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
            if (enter_ack) begin
                addr_byte <= shift_q;
                irq       <= 1'b1;
            end else if (irq_clr) begin
                irq <= 1'b0;
            end
        end
    end

    // Bus drive: gated by enable so a disable frees the lines at once
    always_comb begin
        scl_pull = 1'b0;
        sda_pull = 1'b0;
        unique case (state)
            ST_ACK:  sda_pull = enable;
            ST_HOLD: scl_pull = enable;
            default: ;
        endcase
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_FULL);

    assert_stop_to_search_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ev.stop && !ev.start) |=> (state == ST_SEARCH));

    assert_irq_with_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> sda_pull);

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

endmodule

// File: rtl/i2c_addr_watch.sv
module i2c_addr_watch
    import i2c_aw_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              release_stb,
    input  logic              irq_clr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              irq,
    output logic [ADDR_W:0]   addr_byte
);
    logic [1:0] lines_s;
    bus_ev_t    ev;

    i2c_aw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (lines_s)
    );

    i2c_aw_events events_i (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .ev    (ev)
    );

    i2c_aw_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .dev_addr    (dev_addr),
        .release_stb (release_stb),
        .irq_clr     (irq_clr),
        .ev          (ev),
        .scl_pull    (scl_pull),
        .sda_pull    (sda_pull),
        .irq         (irq),
        .addr_byte   (addr_byte)
    );

    assert_ack_only_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> (addr_byte[ADDR_W:1] == dev_addr));

    assert_hold_until_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull && !release_stb) |=> (scl_pull || !enable));

    assert_hold_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> $past(sda_pull));

endmodule

// File: tb/i2c_addr_watch_tb.sv
`timescale 1ns/1ps
module i2c_addr_watch_tb_top;
    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [6:0] dev_addr = 7'h2D;
    logic       release_stb = 1'b0;
    logic       irq_clr = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       scl_bus;
    logic       sda_bus;
    logic       scl_pull;
    logic       sda_pull;
    logic       irq;
    logic [7:0] addr_byte;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    assign scl_bus = scl_m & ~scl_pull;
    assign sda_bus = sda_m & ~sda_pull;

    i2c_addr_watch dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .dev_addr(dev_addr),
        .release_stb(release_stb), .irq_clr(irq_clr),
        .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .irq(irq), .addr_byte(addr_byte)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic m_stop();
        scl_m = 1'b0; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic m_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7-i]; wq();
            scl_m = 1'b1;   wq();
            scl_m = 1'b0;   wq();
        end
    endtask

    task automatic m_ackclk(output bit acked);
        sda_m = 1'b1; wq();
        scl_m = 1'b1;
        repeat (Q/2) @(negedge clk);
        acked = !sda_bus;
        repeat (Q - Q/2) @(negedge clk);
        scl_m = 1'b0; wq();
    endtask

    task automatic pulse_release();
        release_stb = 1'b1; @(negedge clk);
        release_stb = 1'b0;
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1; @(negedge clk);
        irq_clr = 1'b0;
    endtask

    // Full address phase with expected result computed from the byte
    task automatic addr_txn(input logic [7:0] b);
        bit ack;
        bit exp;
        exp = (b[7:1] == dev_addr);
        m_start();
        m_bits(b, 8);
        m_ackclk(ack);
        if (exp) begin
            chk(ack == 1'b1, "R3/R4", "ack on hit", ack, 1);
            chk(addr_byte == b, "R5", "addr_byte", addr_byte, b);
            chk(irq == 1'b1, "R5", "irq on hit", irq, 1);
            chk(scl_pull == 1'b1, "R6", "scl held", scl_pull, 1);
            wq();
            chk(scl_pull == 1'b1, "R6", "scl still held", scl_pull, 1);
            pulse_release();
            chk(scl_pull == 1'b0, "R6", "scl freed", scl_pull, 0);
            chk(irq == 1'b1, "R9", "irq kept", irq, 1);
            pulse_clr();
            chk(irq == 1'b0, "R9", "irq cleared", irq, 0);
        end else begin
            chk(ack == 1'b0, "R3/R7", "nack on miss", ack, 0);
            chk(irq == 1'b0 && scl_pull == 1'b0, "R7", "no irq/stretch on miss",
                {irq, scl_pull}, 0);
        end
        m_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit ack;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_pull == 0 && sda_pull == 0 && irq == 0 && addr_byte == 0,
            "R1", "reset state", {scl_pull, sda_pull, irq, addr_byte}, 0);

        // R10: disabled, matching address ignored
        m_start(); m_bits(8'h5A, 8); m_ackclk(ack); m_stop();
        chk(ack == 0, "R10", "no ack while disabled", ack, 0);

        enable = 1'b1;
        wq();
        // R2: matching byte without a START
        scl_m = 1'b0; wq();
        m_bits(8'h5A, 8); m_ackclk(ack);
        chk(ack == 0, "R2", "no ack without START", ack, 0);
        m_stop();

        // R3: sweep of every byte value against a fixed address
        for (int v = 0; v < 256; v++) addr_txn(8'(v));

        // R3: every device address with a matching read byte
        for (int a = 0; a < 128; a++) begin
            dev_addr = 7'(a);
            addr_txn({7'(a), 1'b1});
        end
        dev_addr = 7'h2D;

        // R7: byte after a miss ignored until STOP/START
        m_start(); m_bits(8'h10, 8); m_ackclk(ack);
        chk(ack == 0, "R7", "miss nack", ack, 0);
        m_bits(8'h5A, 8); m_ackclk(ack);
        chk(ack == 0, "R7", "byte after miss ignored", ack, 0);
        m_stop();
        addr_txn(8'h5B);

        // R8: repeated START mid-byte restarts reception
        m_start(); m_bits(8'h5A, 4); m_start(); m_bits(8'h5B, 8); m_ackclk(ack);
        chk(ack == 1, "R8", "ack after repeated START", ack, 1);
        chk(addr_byte == 8'h5B, "R8", "byte after restart", addr_byte, 8'h5B);
        pulse_release(); pulse_clr(); m_stop();

        // R8: STOP mid-byte aborts
        m_start(); m_bits(8'h5A, 4); m_stop();
        scl_m = 1'b0; wq();
        m_bits(8'h5A, 8); m_ackclk(ack);
        chk(ack == 0, "R8", "no ack after STOP abort", ack, 0);
        m_stop();

        // R10: disable during hold frees the bus in the same cycle
        m_start(); m_bits(8'h5A, 8); m_ackclk(ack);
        chk(scl_pull == 1, "R10", "in hold before disable", scl_pull, 1);
        enable = 1'b0;
        #1;
        chk(scl_pull == 0 && sda_pull == 0, "R10", "lines freed on disable",
            {scl_pull, sda_pull}, 0);
        @(negedge clk);
        pulse_clr();
        m_stop();
        enable = 1'b1;
        wq();
        m_start(); m_bits(8'h5A, 8); m_ackclk(ack);
        chk(ack == 1, "R10", "ack after re-enable", ack, 1);
        pulse_release(); pulse_clr(); m_stop();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule